// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits between a byte-wide flash array and its host read port. While the embedded engine is running a program or an erase, or has an erase suspended, a read must not return array contents. It must return a status byte that the host polls to find out whether the operation has finished. The generator builds that byte from several inputs: the engine's current mode, the byte being programmed, the mask of sectors under erase, the sector that the read address falls in, and a sticky time-limit flag. When array data should be returned instead, it raises a passthrough flag so that the surrounding read mux selects the array.

The byte uses five fields. A polling bit reads the inverted programmed bit, or 0 during erase. A toggle bit flips on every status read while work is pending. A second toggle bit flips only on reads of a sector that is being erased. A failure bit is set when the engine reports that its time limit has run out. A window bit tells the host whether the sector-erase acceptance window is still open. Both toggle states advance once per read, and a read is counted on the rising edge of the read strobe. The outputs are registered and change only when a read is taken.

Top module: `flash_status_gen`

## Requirements
- R1: After rst_ni is released, status_o is 8'h00 and pass_o is 1. The first status read after reset returns 0 in both toggle bits (6 and 2).
- R2: A read is taken at the first rising clock edge where rd_stb_i is sampled high after it was sampled low. status_o and pass_o update at that edge and hold their values until the next read is taken.
- R3: In mode 1 (program) and mode 5 (program during erase suspend), bit 7 is the complement of prog_data_i[7], and bit 2 reads 0. Bit 5 reads 0 in mode 5.
- R4: In mode 2 (erase window) and mode 3 (erase running), bit 7 reads 0. Bit 3 reads 0 in mode 2 and 1 in mode 3.
- R5: In modes 1, 2, 3 and 5, bit 6 returns the toggle state and that state inverts after every read.
- R6: timeout_i sets a failure flag that stays set until clr_fail_i is applied; clear wins when both are applied in the same cycle. Bit 5 shows the flag in modes 1, 2 and 3.
- R7: In modes 2, 3 and 4, bit 2 returns the sector toggle state. That state inverts only after a read whose sector is set in busy_mask_i; reads of other sectors leave it unchanged.
- R8: In mode 4 (erase suspended), a read of a sector in busy_mask_i returns bit 7 = 1 and bit 6 unchanged from the previous status read, with bit 2 toggling, and pass_o = 0. A read of any other sector gives pass_o = 1 and status_o = 0.
- R9: Bits 4, 1 and 0 always read 0. Mode 0 (idle) and the unused codes 6 and 7 give pass_o = 1 and status_o = 0, and do not advance either toggle.
- R10: Neither toggle advances while rd_stb_i is held high after a read or while it stays low.
- R11: The sector of a read is rd_addr_i[ADDR_W-1 -: SECT_W], and bit i of busy_mask_i marks sector i as under erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Engine mode: 0 idle, 1 program, 2 erase window, 3 erase running, 4 erase suspended, 5 program during suspend |
| prog_data_i | input | 8 | Byte being programmed |
| busy_mask_i | input | N_SECT | Sectors under erase, active or suspended |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_stb_i | input | 1 | Host read strobe, one read per rising edge |
| timeout_i | input | 1 | Engine time limit exceeded |
| clr_fail_i | input | 1 | Reset command, clears the failure flag |
| status_o | output | 8 | Status byte of the last read taken |
| pass_o | output | 1 | Last read must return array data |

## Verification
Each read result is due at the clock edge where the strobe is first sampled high. The bench raises the strobe at a falling edge, waits one rising edge, and compares at the next falling edge. It then drops the strobe for a full cycle, so every read is a separate rise. The failure flag needs one edge to settle after timeout_i or clr_fail_i, and the bench leaves at least one cycle before the next read. To check that a held strobe and idle cycles have no effect, the bench compares outputs across those cycles and then confirms on the next read that each toggle bit moved by exactly one step.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERS_WIN   = 3'd2,
    MODE_ERS_RUN   = 3'd3,
    MODE_ERS_SUSP  = 3'd4,
    MODE_SUSP_PROG = 3'd5
  } mode_e;

  localparam int unsigned STAT_W   = 8;
  localparam int unsigned B_POLL   = 7;
  localparam int unsigned B_TOG    = 6;
  localparam int unsigned B_FAIL   = 5;
  localparam int unsigned B_WIN    = 3;
  localparam int unsigned B_STOG   = 2;
  localparam int unsigned N_TOG    = 2;
  localparam int unsigned T_OP     = 0;
  localparam int unsigned T_SECT   = 1;
endpackage

// File: rtl/flash_stat_sect_dec.sv
module flash_stat_sect_dec #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned N_SECT = 8,
  localparam int unsigned SECT_W = $clog2(N_SECT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SECT-1:0] busy_i,
  output logic [N_SECT-1:0] sect_oh_o,
  output logic              hit_o
);
  logic [SECT_W-1:0] sect_idx;
  assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];

  for (genvar g = 0; g < N_SECT; g++) begin : g_oh
    assign sect_oh_o[g] = (sect_idx == SECT_W'(g));
  end

  assign hit_o = |(sect_oh_o & busy_i);
endmodule

// File: rtl/flash_stat_fail.sv
module flash_stat_fail (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o); // R6
  AST_FAIL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o); // R6
endmodule

// File: rtl/flash_stat_toggle.sv
module flash_stat_toggle #(
  parameter int unsigned N_TOG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_rise_i,
  input  logic [N_TOG-1:0] adv_i,
  output logic [N_TOG-1:0] tog_o
);
  for (genvar g = 0; g < N_TOG; g++) begin : g_tog
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     tog_o[g] <= 1'b0;
      else if (rd_rise_i && adv_i[g])  tog_o[g] <= ~tog_o[g];
    end

    AST_TOG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_rise_i && adv_i[g] |=> tog_o[g] != $past(tog_o[g])); // R5
  end

  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_rise_i |=> $stable(tog_o)); // R10
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned N_SECT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [7:0]        prog_data_i,
  input  logic [N_SECT-1:0] busy_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_stb_i,
  input  logic              timeout_i,
  input  logic              clr_fail_i,
  output logic [7:0]        status_o,
  output logic              pass_o
);
  mode_e              mode;
  logic               rd_q, rd_rise;
  logic [N_SECT-1:0]  sect_oh;
  logic               hit, fail;
  logic [N_TOG-1:0]   tog, adv;
  logic [STAT_W-1:0]  nxt_stat;
  logic               nxt_pass;

  assign mode    = mode_e'(mode_i);
  assign rd_rise = rd_stb_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_stb_i;
  end

  flash_stat_sect_dec #(.ADDR_W(ADDR_W), .N_SECT(N_SECT)) sect_dec_i (
    .addr_i   (rd_addr_i),
    .busy_i   (busy_mask_i),
    .sect_oh_o(sect_oh),
    .hit_o    (hit)
  );

  flash_stat_fail fail_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (timeout_i),
    .clr_i (clr_fail_i),
    .flag_o(fail)
  );

  flash_stat_toggle #(.N_TOG(N_TOG)) toggle_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_rise_i(rd_rise),
    .adv_i    (adv),
    .tog_o    (tog)
  );

  always_comb begin
    nxt_stat = '0;
    nxt_pass = 1'b0;
    adv      = '0;
    case (mode)
      MODE_PROG, MODE_SUSP_PROG: begin
        nxt_stat[B_POLL] = ~prog_data_i[7];
        nxt_stat[B_TOG]  = tog[T_OP];
        nxt_stat[B_FAIL] = (mode == MODE_PROG) && fail;
        adv[T_OP]        = 1'b1;
      end
      MODE_ERS_WIN, MODE_ERS_RUN: begin
        nxt_stat[B_TOG]  = tog[T_OP];
        nxt_stat[B_FAIL] = fail;
        nxt_stat[B_WIN]  = (mode == MODE_ERS_RUN);
        nxt_stat[B_STOG] = tog[T_SECT];
        adv[T_OP]        = 1'b1;
        adv[T_SECT]      = hit;
      end
      MODE_ERS_SUSP: begin
        if (hit) begin
          nxt_stat[B_POLL] = 1'b1;
          nxt_stat[B_TOG]  = tog[T_OP];
          nxt_stat[B_STOG] = tog[T_SECT];
          adv[T_SECT]      = 1'b1;
        end else begin
          nxt_pass = 1'b1;
        end
      end
      default: nxt_pass = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      pass_o   <= 1'b1;
    end else if (rd_rise) begin
      status_o <= nxt_stat;
      pass_o   <= nxt_pass;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_rise |=> $stable(status_o) && $stable(pass_o)); // R2
  AST_PASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> status_o == '0); // R9
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] == 1'b0 && status_o[1:0] == 2'b00); // R9
  AST_SUSP_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rise && mode == MODE_ERS_SUSP && (sect_oh & busy_mask_i) != '0
      |=> status_o[B_POLL] && !pass_o && $stable(tog[T_OP])); // R8
endmodule

// File: tb/flash_status_gen_tb_top.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = '0;
  logic [7:0] prog_data_i = '0;
  logic [7:0] busy_mask_i = '0;
  logic [18:0] rd_addr_i = '0;
  logic       rd_stb_i = 1'b0;
  logic       timeout_i = 1'b0;
  logic       clr_fail_i = 1'b0;
  logic [7:0] status_o;
  logic       pass_o;

  int n_chk = 0;
  int n_fail = 0;
  logic m_t6 = 1'b0, m_t2 = 1'b0, m_fail = 1'b0;

  always #2.5 clk_i = ~clk_i;

  flash_status_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .prog_data_i(prog_data_i),
    .busy_mask_i(busy_mask_i), .rd_addr_i(rd_addr_i), .rd_stb_i(rd_stb_i),
    .timeout_i(timeout_i), .clr_fail_i(clr_fail_i), .status_o(status_o), .pass_o(pass_o)
  );

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pass,status} actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] m, input logic [2:0] sec, input logic [7:0] busy,
                    input logic [7:0] d);
    logic [7:0] es;
    logic ep, hit, a6, a2;
    string tag;
    @(negedge clk_i);
    mode_i = m; rd_addr_i = {sec, 16'h1234}; busy_mask_i = busy; prog_data_i = d;
    rd_stb_i = 1'b1;
    hit = busy[sec];
    es = '0; ep = 1'b0; a6 = 1'b0; a2 = 1'b0;
    case (m)
      3'd1: begin es = {~d[7], m_t6, m_fail, 5'b0}; a6 = 1'b1; tag = "R3 R5 R6"; end
      3'd5: begin es = {~d[7], m_t6, 6'b0}; a6 = 1'b1; tag = "R3 R5 R6"; end
      3'd2, 3'd3: begin
        es = {1'b0, m_t6, m_fail, 1'b0, (m == 3'd3), m_t2, 2'b0};
        a6 = 1'b1; a2 = hit; tag = "R4 R5 R7 R11";
      end
      3'd4: begin
        if (hit) begin es = {1'b1, m_t6, 3'b0, m_t2, 2'b0}; a2 = 1'b1; end
        else ep = 1'b1;
        tag = "R8 R7 R11";
      end
      default: begin ep = 1'b1; tag = "R9"; end
    endcase
    @(posedge clk_i);
    @(negedge clk_i);
    check({pass_o, status_o}, {ep, es}, tag);
    if (a6) m_t6 = ~m_t6;
    if (a2) m_t2 = ~m_t2;
    rd_stb_i = 1'b0;
  endtask

  task automatic sweep();
    logic [7:0] masks [3] = '{8'h00, 8'h5A, 8'hFF};
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 3; k++)
          for (int d = 0; d < 2; d++)
            rd(3'(m), 3'(s), masks[k], d ? 8'h80 : 8'h7F);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] held;
    repeat (3) @(negedge clk_i);
    check({pass_o, status_o}, 9'h100, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({pass_o, status_o}, 9'h100, "R1 after release");
    rd(3'd2, 3'd1, 8'h02, 8'h00); // R1: first read has both toggles at 0

    sweep();

    // R2 R10: held strobe and idle cycles change nothing
    rd(3'd3, 3'd0, 8'h01, 8'h00);
    held = {pass_o, status_o};
    rd_stb_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check({pass_o, status_o}, held, "R2 R10 held strobe");
    rd_stb_i = 1'b0;
    mode_i = 3'd1; prog_data_i = 8'h00;
    repeat (5) @(negedge clk_i);
    check({pass_o, status_o}, held, "R2 idle cycles");
    rd(3'd3, 3'd0, 8'h01, 8'h00); // R10: single step seen

    // R6: sticky failure flag
    @(negedge clk_i); timeout_i = 1'b1;
    @(negedge clk_i); timeout_i = 1'b0; m_fail = 1'b1;
    repeat (3) @(negedge clk_i);
    for (int m = 1; m < 6; m++) rd(3'(m), 3'd2, 8'h04, 8'hFF);
    sweep();
    @(negedge clk_i); timeout_i = 1'b1; clr_fail_i = 1'b1;
    @(negedge clk_i); timeout_i = 1'b0; clr_fail_i = 1'b0; m_fail = 1'b0;
    for (int m = 1; m < 4; m++) rd(3'(m), 3'd7, 8'h80, 8'h00);

    repeat (2) @(negedge clk_i);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule